// File: doc/BRIEF.md
# Preset-Interval Timer/Counter

This block produces a periodic interrupt request for a small 4-bit controller. A 4-bit preset value picks the length of the interval. In timer mode the block counts instruction-cycle ticks. In counter mode it counts rising edges on an external pulse pin instead. When an interval ends, the block raises a sticky timer flag and a one-cycle interrupt request toward the interrupt logic. It then reloads the preset at once and starts the next interval, so software does not need to rewrite it.

Internally the events pass through a divide-by-64 prescaler into a 4-bit up-counter. The counter starts at the preset value and wraps after reaching 15. A preset value n therefore gives an interval of (16 − n) × 64 events: n = 0 is the longest at 1024 events and n = 15 the shortest at 64. At a 100 kHz instruction rate this is 10.24 ms down to 0.64 ms.

Top module: `interval_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irqPulse` and `timerFlag` are both 0.
- R2: In timer mode (`countMode` = 0) with preset n, an interval ends on the clock edge that counts the (16 − n) × 64-th event. An event is a cycle with `cycleTick` = 1. Counting starts after the last preset write, so n = 0 gives 1024 and n = 15 gives 64.
- R3: In timer mode, cycles with `cycleTick` = 0 do not advance the interval.
- R4: After an interval ends, the preset is reloaded automatically and the next interval of the same length starts with the following event.
- R5: In counter mode (`countMode` = 1), only rising edges of `extPulse` are events. The pin passes through two synchronising flops, so a rise first seen at clock edge k is counted at edge k + 2. Falling edges and `cycleTick` are ignored in this mode.
- R6: When `presetWe` is high at a clock edge, `presetData` becomes the new preset and the count restarts from zero events. This write takes priority over an interval end at the same edge, which is then lost.
- R7: `irqPulse` is high for exactly the one cycle after the edge that ends an interval.
- R8: `timerFlag` is set by the edge that ends an interval and cleared by `flagClr` at a later edge. If both happen at the same edge, the set wins.
- R9: The preset after reset is 0, so the first interval without a write is 1024 events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycleTick | input | 1 | One-cycle strobe per instruction cycle (timer mode event) |
| countMode | input | 1 | 0 = count ticks, 1 = count external pin rising edges |
| extPulse | input | 1 | Asynchronous external pulse pin |
| presetWe | input | 1 | Write strobe for the preset |
| presetData | input | 4 | New preset value n |
| flagClr | input | 1 | Clear strobe for the timer flag |
| timerFlag | output | 1 | Sticky end-of-interval flag |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The bench targets the shortest (n = 15) and longest (n = 0, reached from reset) intervals. A wrong prescaler width or an off-by-one in the counter would move every request by whole prescaler periods or by one event.

It places a preset write exactly on the event that would end an interval. A design without write priority would emit a stray request there.

It holds `flagClr` high across interval ends. A design where the clear wins would never show the flag.

In counter mode it drives random pin levels with busy ticks. A design that counts both pin edges, counts ticks, or bypasses a synchroniser stage would shift or multiply the requests.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic load;   // preset write: restart interval
    logic carry;  // prescaler completed one period
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycleTick,
  input  logic       countMode,
  input  logic       extPulse,
  input  logic       presetWe,
  output tmrStrobe_t strobe
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  // synchroniser stages plus one edge-detect stage
  logic [SYNC_STAGES:0] syncQ;
  logic                 pinRise;
  logic                 evt;
  logic [PRE_W-1:0]     preCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[SYNC_STAGES-1:0], extPulse};
  end

  assign pinRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign evt     = countMode ? pinRise : cycleTick;

  always_ff @(posedge clk) begin
    if (!rst_n)        preCnt <= '0;
    else if (presetWe) preCnt <= '0;
    else if (evt)      preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strobe.load  = presetWe;
    strobe.carry = evt && (preCnt == PRE_MAX) && !presetWe;
  end

  // R3
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !presetWe) |=> $stable(preCnt));

  // R6
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presetWe |=> (preCnt == '0));
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] presetData,
  input  logic             flagClr,
  output logic             timerFlag,
  output logic             irqPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] presetQ;
  logic [CNT_W-1:0] cntQ;
  logic             wrap;
  logic             flagQ;
  logic             irqQ;

  assign wrap = strobe.carry && (cntQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presetQ <= '0;
      cntQ    <= '0;
    end else if (strobe.load) begin
      presetQ <= presetData;
      cntQ    <= presetData;
    end else if (strobe.carry) begin
      cntQ <= wrap ? presetQ : cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqQ  <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      irqQ <= wrap;
      if (wrap)         flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
    end
  end

  assign irqPulse  = irqQ;
  assign timerFlag = flagQ;

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |=> !irqPulse);

  // R8
  flag_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> timerFlag);

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timerFlag) |-> $past(flagClr));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> (cntQ == presetQ));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (cntQ == $past(presetData)) && !irqPulse);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int PRE_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycleTick,
  input  logic             countMode,
  input  logic             extPulse,
  input  logic             presetWe,
  input  logic [CNT_W-1:0] presetData,
  input  logic             flagClr,
  output logic             timerFlag,
  output logic             irqPulse
);
  tmrStrobe_t strobe;

  tmr_ctrl #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .cycleTick(cycleTick), .countMode(countMode),
    .extPulse(extPulse), .presetWe(presetWe), .strobe(strobe)
  );

  tmr_dpath #(.CNT_W(CNT_W)) uDpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .presetData(presetData),
    .flagClr(flagClr), .timerFlag(timerFlag), .irqPulse(irqPulse)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irqPulse && !timerFlag));
endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycleTick = 1'b0, countMode = 1'b0, extPulse = 1'b0;
  logic presetWe = 1'b0, flagClr = 1'b0;
  logic [3:0] presetData = 4'd0;
  logic timerFlag, irqPulse;

  int checks = 0, fails = 0;
  // bench reference state
  int mPre = 0, mEv = 0;
  logic eIrq = 1'b0, eFlag = 1'b0;
  logic [2:0] pinHist = 3'b000;

  always #5 clk = ~clk;

  interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .cycleTick(cycleTick), .countMode(countMode),
    .extPulse(extPulse), .presetWe(presetWe), .presetData(presetData),
    .flagClr(flagClr), .timerFlag(timerFlag), .irqPulse(irqPulse)
  );

  function automatic int intervalOf(input int n);
    return (16 - n) * 64;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic evtNow;
    @(posedge clk);
    evtNow  = countMode ? (pinHist[1] & ~pinHist[2]) : cycleTick;
    pinHist = {pinHist[1:0], extPulse};
    eIrq = 1'b0;
    if (presetWe) begin
      mPre = int'(presetData);
      mEv  = 0;
    end else if (evtNow) begin
      mEv++;
      if (mEv == intervalOf(mPre)) begin
        eIrq = 1'b1;
        mEv  = 0;
      end
    end
    if (eIrq) eFlag = 1'b1;
    else if (flagClr) eFlag = 1'b0;
    @(negedge clk);
    check(tag, "irqPulse", irqPulse, eIrq);
    check(tag, "timerFlag", timerFlag, eFlag);
  endtask

  task automatic writePreset(input int n, input string tag);
    presetWe = 1'b1; presetData = 4'(n);
    step(tag);
    presetWe = 1'b0;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "irqPulse", irqPulse, 1'b0);
    check("R1", "timerFlag", timerFlag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "irqPulse", irqPulse, 1'b0);
    check("R1", "timerFlag", timerFlag, 1'b0);
    pinHist = 3'b000;

    // R9 and R2: default preset 0, tick every cycle -> 1024
    cycleTick = 1'b1;
    repeat (1100) step("R9");

    // R2, R4, R7: shortest interval, repeated
    writePreset(15, "R2");
    repeat (300) step("R4");

    // R3: sparse ticks with random clears
    for (int r = 0; r < 6; r++) begin
      writePreset(12 + int'($urandom_range(3)), "R3");
      for (int i = 0; i < 600; i++) begin
        cycleTick = 1'($urandom_range(1));
        flagClr   = ($urandom_range(7) == 0);
        step("R3");
      end
    end
    flagClr = 1'b0;

    // R6: write landing on the interval-ending event
    cycleTick = 1'b1;
    writePreset(15, "R6");
    repeat (63) step("R6");
    writePreset(15, "R6");
    repeat (70) step("R6");
    // R6: random writes during running
    for (int i = 0; i < 1500; i++) begin
      presetWe   = ($urandom_range(99) == 0);
      presetData = 4'(13 + $urandom_range(2));
      cycleTick  = ($urandom_range(3) != 0);
      step("R6");
    end
    presetWe = 1'b0;

    // R8: clear held high, set must win
    cycleTick = 1'b1;
    writePreset(15, "R8");
    flagClr = 1'b1;
    repeat (200) step("R8");
    flagClr = 1'b0;
    repeat (70) step("R8");

    // R5: counter mode, toggling pin, ticks busy
    countMode = 1'b1;
    writePreset(15, "R5");
    for (int i = 0; i < 600; i++) begin
      extPulse  = ~extPulse;
      cycleTick = 1'($urandom_range(1));
      step("R5");
    end
    // R5: random pin levels
    writePreset(14, "R5");
    for (int i = 0; i < 2500; i++) begin
      extPulse  = 1'($urandom_range(1));
      cycleTick = 1'b1;
      flagClr   = ($urandom_range(15) == 0);
      step("R5");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule